// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter

This block decides which interrupt a small 8-bit processor core takes next. It serves two kinds of source. Latched sources record a single-cycle event in a pending flag. Level sources have no storage and request service only while their condition input is high. Every source has its own enable bit, and one global enable gates them all. The block combines these into a single request and the vector index of the winning source.

The core drives three strobes into the block. The instruction-boundary strobe marks a point where an interrupt may be taken. The return strobe marks the end of a handler. The disable strobe marks an instruction that turns interrupts off. An acceptance happens in any cycle where the boundary strobe and the request are both high. In that cycle the block drops the global enable and clears the pending flag of the accepted latched source.

After a return, one main-program instruction always runs before another request can be taken. A disable masks the request in the same cycle it arrives. Vector fetch, program-counter stacking and status saving are left to the core.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset all pending flags, all per-source enables and the global enable are clear, `irq_o` is low and `vec_o` is 0.
- R2: A latched source sets its pending flag on an event even while its enable or the global enable is clear. The flag then stays set until the source is accepted or cleared by software.
- R3: Writing a 1 to bit i of `flag_clr_i` clears pending flag i. If an event on flag i arrives in the same cycle, the event wins and the flag stays set.
- R4: Level source j (index N_FLAG+j) requests only in cycles where `level_cond_i[j]` and its enable are both high. A condition that goes away before the enable is set leaves no request behind.
- R5: Latched sources take indices 0..N_FLAG-1, and level sources take N_FLAG..N_FLAG+N_LEVEL-1. Enable bit i belongs to index i. The lowest enabled, requesting index wins, and `vec_o` carries that index.
- R6: `irq_o` is high only while the global enable is on, no post-return block is armed, and some enabled source requests. Flags held while the global enable was off are served one per acceptance, in priority order.
- R7: An acceptance (`boundary_i` high while `irq_o` is high) clears the global enable and the accepted latched source's flag, both visible from the next cycle.
- R8: `reti_i` sets the global enable and arms a block. The next `boundary_i` strobe cannot accept and releases the block, so a pending request is taken no earlier than the boundary after that.
- R9: `gie_clr_i` forces `irq_o` low in the same cycle, so no acceptance can happen then, and the global enable is clear from the next cycle. It wins over a simultaneous `gie_set_i` or `reti_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_evt_i | input | N_FLAG | Event pulses for the latched sources |
| flag_clr_i | input | N_FLAG | Write-one-to-clear mask for the pending flags |
| level_cond_i | input | N_LEVEL | Condition inputs for the level sources |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N_FLAG+N_LEVEL | New enable bits, one per source index |
| gie_set_i | input | 1 | Enable-interrupts instruction strobe |
| gie_clr_i | input | 1 | Disable-interrupts instruction strobe |
| reti_i | input | 1 | Return-from-handler strobe |
| boundary_i | input | 1 | Instruction-boundary strobe (acceptance point) |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | IW | Index of the winning source |

## Verification
The bench issues a disable together with a boundary strobe while a request is live. A design that registered the disable would accept the request in that cycle, and the flag would no longer be pending when the global enable returns. It strobes a boundary directly after a return with a flag pending. A design without the one-instruction block would take the interrupt there, while a block released too late would miss the following boundary. It also pulses a clear and an event on the same flag in one cycle, where a wrong priority loses the event. It drops a level condition before its enable is set, where a design that latched level sources would later raise a spurious request. Finally, it stacks several held flags and a level source, where a reversed encoder or a missed flag clear on acceptance would deliver them out of order or repeat one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Width of an index able to address n sources (at least one bit).
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N_FLAG = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_FLAG-1:0] evt_i,
   input  logic [N_FLAG-1:0] sw_clr_i,
   input  logic [N_FLAG-1:0] take_clr_i,
   output logic [N_FLAG-1:0] pend_o
);

   generate
      if (N_FLAG < 1) begin : g_bad_n
         $error("irq_flag_bank: N_FLAG must be at least 1");
      end
   endgenerate

   // One sticky latch per source; a new event beats any clear.
   for (genvar i = 0; i < N_FLAG; i++) begin : g_bit
      logic pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (evt_i[i]) begin
            pend_q <= 1'b1;
         end else if (sw_clr_i[i] || take_clr_i[i]) begin
            pend_q <= 1'b0;
         end
      end
      assign pend_o[i] = pend_q;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N_SRC = 6,
   parameter int IW    = 3
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [IW-1:0]    idx_o
);

   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("irq_prio_pick: N_SRC must be at least 2");
      end
      if ((1 << IW) < N_SRC) begin : g_bad_w
         $error("irq_prio_pick: IW too narrow for N_SRC");
      end
   endgenerate

   // Scan from the top down so the lowest requesting index is kept last.
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            any_o = 1'b1;
            idx_o = IW'(k);
         end
      end
   end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic reti_i,
   input  logic boundary_i,
   input  logic take_i,
   output logic gie_o,
   output logic block_o
);

   logic gie_q;
   logic block_q;

   // Global enable: disable and acceptance beat set and return.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
      end else if (clr_i || take_i) begin
         gie_q <= 1'b0;
      end else if (set_i || reti_i) begin
         gie_q <= 1'b1;
      end
   end

   // One-instruction hold after a return, dropped at the next boundary.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         block_q <= 1'b0;
      end else if (reti_i) begin
         block_q <= 1'b1;
      end else if (boundary_i) begin
         block_q <= 1'b0;
      end
   end

   assign gie_o   = gie_q;
   assign block_o = block_q;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N_FLAG  = 4,
   parameter int N_LEVEL = 2,
   parameter int IW      = irq_arb_pkg::idx_width(N_FLAG + N_LEVEL)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_FLAG-1:0]          flag_evt_i,
   input  logic [N_FLAG-1:0]          flag_clr_i,
   input  logic [N_LEVEL-1:0]         level_cond_i,
   input  logic                       en_wr_i,
   input  logic [N_FLAG+N_LEVEL-1:0]  en_wdata_i,
   input  logic                       gie_set_i,
   input  logic                       gie_clr_i,
   input  logic                       reti_i,
   input  logic                       boundary_i,
   output logic                       irq_o,
   output logic [IW-1:0]              vec_o
);

   localparam int N_SRC = N_FLAG + N_LEVEL;

   generate
      if (N_FLAG < 1) begin : g_bad_flag
         $error("irq_prio_arb: N_FLAG must be at least 1");
      end
      if (N_LEVEL < 1) begin : g_bad_level
         $error("irq_prio_arb: N_LEVEL must be at least 1");
      end
      if (IW < irq_arb_pkg::idx_width(N_SRC)) begin : g_bad_iw
         $error("irq_prio_arb: IW too narrow");
      end
   endgenerate

   logic [N_SRC-1:0]  en_q;
   logic [N_FLAG-1:0] flag_q;
   logic [N_FLAG-1:0] take_clr;
   logic [N_SRC-1:0]  req;
   logic [IW-1:0]     win_idx;
   logic              win_any;
   logic              gie_q;
   logic              block_q;
   logic              take;

   // Per-source enable register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr_i) begin
         en_q <= en_wdata_i;
      end
   end

   irq_flag_bank #(.N_FLAG(N_FLAG)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (flag_evt_i),
      .sw_clr_i   (flag_clr_i),
      .take_clr_i (take_clr),
      .pend_o     (flag_q)
   );

   // Latched sources occupy the low indices, level sources the high ones.
   assign req = en_q & {level_cond_i, flag_q};

   irq_prio_pick #(.N_SRC(N_SRC), .IW(IW)) u_pick (
      .req_i (req),
      .any_o (win_any),
      .idx_o (win_idx)
   );

   irq_gate_ctrl u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (gie_set_i),
      .clr_i      (gie_clr_i),
      .reti_i     (reti_i),
      .boundary_i (boundary_i),
      .take_i     (take),
      .gie_o      (gie_q),
      .block_o    (block_q)
   );

   // A disable in flight masks the request in its own cycle.
   assign irq_o = win_any && gie_q && !block_q && !gie_clr_i;
   assign vec_o = win_idx;
   assign take  = irq_o && boundary_i;

   for (genvar i = 0; i < N_FLAG; i++) begin : g_take
      assign take_clr[i] = take && (win_idx == IW'(i));
   end

endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
   parameter int N_FLAG  = 4,
   parameter int N_LEVEL = 2,
   parameter int IW      = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [N_FLAG-1:0]         flag_evt_i,
   input logic [N_LEVEL-1:0]        level_cond_i,
   input logic                      gie_clr_i,
   input logic                      reti_i,
   input logic                      boundary_i,
   input logic                      irq_o,
   input logic [IW-1:0]             vec_o,
   input logic [N_FLAG+N_LEVEL-1:0] en_q,
   input logic [N_FLAG-1:0]         pend,
   input logic                      gie
);

   localparam int N_SRC = N_FLAG + N_LEVEL;

   // R2 / R3: an event always leaves its flag set on the next cycle.
   assert_evt_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      |flag_evt_i |=> ((pend & $past(flag_evt_i)) == $past(flag_evt_i)));

   // R4: a level winner must have a live, enabled condition.
   assert_level_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && (int'(vec_o) >= N_FLAG)) |-> |(level_cond_i & en_q[N_SRC-1:N_FLAG]));

   // R5: the vector names an existing source.
   assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (int'(vec_o) < N_SRC));

   // R6: no request without the global enable.
   assert_gie_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie);

   // R7: an acceptance drops the request on the next cycle.
   assert_take_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && boundary_i) |=> !irq_o);

   // R8: a return blocks the request for the following cycle.
   assert_reti_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reti_i |=> !irq_o);

   // R9: a disable masks now and after.
   assert_cli_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr_i |-> !irq_o);
   assert_cli_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr_i |=> !irq_o);

endmodule

bind irq_prio_arb irq_prio_arb_chk #(
   .N_FLAG  (N_FLAG),
   .N_LEVEL (N_LEVEL),
   .IW      (IW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flag_evt_i   (flag_evt_i),
   .level_cond_i (level_cond_i),
   .gie_clr_i    (gie_clr_i),
   .reti_i       (reti_i),
   .boundary_i   (boundary_i),
   .irq_o        (irq_o),
   .vec_o        (vec_o),
   .en_q         (en_q),
   .pend         (flag_q),
   .gie          (gie_q)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;

   localparam int NF = 4;
   localparam int NL = 2;
   localparam int NS = NF + NL;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] flag_evt_i = '0;
   logic [NF-1:0] flag_clr_i = '0;
   logic [NL-1:0] level_cond_i = '0;
   logic          en_wr_i = 1'b0;
   logic [NS-1:0] en_wdata_i = '0;
   logic          gie_set_i = 1'b0;
   logic          gie_clr_i = 1'b0;
   logic          reti_i = 1'b0;
   logic          boundary_i = 1'b0;
   logic          irq_o;
   logic [IW-1:0] vec_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_prio_arb #(.N_FLAG(NF), .N_LEVEL(NL), .IW(IW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .flag_evt_i   (flag_evt_i),
      .flag_clr_i   (flag_clr_i),
      .level_cond_i (level_cond_i),
      .en_wr_i      (en_wr_i),
      .en_wdata_i   (en_wdata_i),
      .gie_set_i    (gie_set_i),
      .gie_clr_i    (gie_clr_i),
      .reti_i       (reti_i),
      .boundary_i   (boundary_i),
      .irq_o        (irq_o),
      .vec_o        (vec_o)
   );

   // Always called at a falling edge; advances one full cycle.
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_req(input string req, input logic exp_irq, input int exp_vec);
      #1;
      n_chk++;
      if (irq_o !== exp_irq || (exp_irq && int'(vec_o) != exp_vec)) begin
         n_bad++;
         $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                  req, irq_o, vec_o, exp_irq, exp_vec);
      end
   endtask

   task automatic write_en(input logic [NS-1:0] m);
      en_wr_i = 1'b1; en_wdata_i = m;
      tick();
      en_wr_i = 1'b0;
   endtask

   task automatic pulse_evt(input logic [NF-1:0] m);
      flag_evt_i = m;
      tick();
      flag_evt_i = '0;
   endtask

   task automatic set_gie();
      gie_set_i = 1'b1;
      tick();
      gie_set_i = 1'b0;
   endtask

   task automatic accept();
      boundary_i = 1'b1;
      tick();
      boundary_i = 1'b0;
   endtask

   task automatic cleanup();
      flag_clr_i = '1; gie_clr_i = 1'b1; level_cond_i = '0;
      en_wr_i = 1'b1; en_wdata_i = '0;
      tick();
      flag_clr_i = '0; gie_clr_i = 1'b0; en_wr_i = 1'b0;
   endtask

   task automatic t_reset();
      expect_req("R1 reset idle", 1'b0, 0);
      n_chk++;
      if (vec_o !== '0) begin
         n_bad++;
         $display("FAIL R1 reset vec: actual %0d expected 0", vec_o);
      end
      write_en('1);
      pulse_evt(4'b0001);
      expect_req("R1 global enable clear after reset", 1'b0, 0);
      cleanup();
   endtask

   task automatic t_flag_latch();
      pulse_evt(4'b0100);
      set_gie();
      expect_req("R2 flag held while source disabled", 1'b0, 0);
      write_en(6'b000100);
      expect_req("R2 held flag requests once enabled", 1'b1, 2);
      accept();
      expect_req("R7 acceptance drops global enable", 1'b0, 0);
      set_gie();
      expect_req("R7 accepted flag cleared", 1'b0, 0);
      cleanup();
   endtask

   task automatic t_w1c();
      pulse_evt(4'b0010);
      write_en(6'b000010);
      set_gie();
      expect_req("R3 flag present before clear", 1'b1, 1);
      flag_clr_i = 4'b0010;
      tick();
      flag_clr_i = '0;
      expect_req("R3 write-one clears flag", 1'b0, 0);
      flag_clr_i = 4'b0010; flag_evt_i = 4'b0010;
      tick();
      flag_clr_i = '0; flag_evt_i = '0;
      expect_req("R3 event beats clear", 1'b1, 1);
      cleanup();
   endtask

   task automatic t_level();
      write_en(6'b010000);
      set_gie();
      level_cond_i = 2'b01;
      expect_req("R4 level requests while present", 1'b1, 4);
      level_cond_i = 2'b00;
      expect_req("R4 level gone drops request", 1'b0, 0);
      write_en(6'b000000);
      level_cond_i = 2'b10;
      tick();
      level_cond_i = 2'b00;
      write_en(6'b100000);
      expect_req("R4 level not remembered", 1'b0, 0);
      cleanup();
   endtask

   task automatic t_priority();
      write_en('1);
      pulse_evt(4'b1010);
      level_cond_i = 2'b10;
      expect_req("R6 held while global enable off", 1'b0, 0);
      set_gie();
      expect_req("R5 lowest index first", 1'b1, 1);
      accept();
      set_gie();
      expect_req("R6 next held flag", 1'b1, 3);
      accept();
      set_gie();
      expect_req("R5 level source after flags", 1'b1, 5);
      accept();
      level_cond_i = 2'b00;
      set_gie();
      expect_req("R6 all served", 1'b0, 0);
      cleanup();
   endtask

   task automatic t_reti();
      write_en(6'b000001);
      pulse_evt(4'b0001);
      reti_i = 1'b1;
      tick();
      reti_i = 1'b0;
      expect_req("R8 blocked right after return", 1'b0, 0);
      boundary_i = 1'b1;
      expect_req("R8 first boundary cannot accept", 1'b0, 0);
      tick();
      boundary_i = 1'b0;
      expect_req("R8 request after one instruction", 1'b1, 0);
      accept();
      expect_req("R8 accepted at later boundary", 1'b0, 0);
      cleanup();
   endtask

   task automatic t_cli();
      write_en(6'b000100);
      pulse_evt(4'b0100);
      set_gie();
      expect_req("R9 request live before disable", 1'b1, 2);
      gie_clr_i = 1'b1; boundary_i = 1'b1;
      expect_req("R9 disable masks same cycle", 1'b0, 0);
      tick();
      gie_clr_i = 1'b0; boundary_i = 1'b0;
      expect_req("R9 stays off after disable", 1'b0, 0);
      set_gie();
      expect_req("R9 flag not accepted by disable", 1'b1, 2);
      flag_clr_i = '1;
      tick();
      flag_clr_i = '0;
      gie_clr_i = 1'b1; flag_evt_i = 4'b0100;
      tick();
      gie_clr_i = 1'b0; flag_evt_i = '0;
      expect_req("R9 event with disable not served", 1'b0, 0);
      gie_clr_i = 1'b1; gie_set_i = 1'b1;
      tick();
      gie_clr_i = 1'b0; gie_set_i = 1'b0;
      expect_req("R9 disable beats set", 1'b0, 0);
      cleanup();
   endtask

   initial begin
      @(negedge clk);
      tick();
      tick();
      rst_n = 1'b1;
      t_reset();
      t_flag_latch();
      t_w1c();
      t_level();
      t_priority();
      t_reti();
      t_cli();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule